// File: doc/BRIEF.md
# Key Slot Access Controller

This block guards a store of key slots, each holding four 32-bit value words, a 4-bit permission header and a 32-bit destination header. A secure bus master picks one slot at a time by writing a select register. The block then grants or refuses reads and writes of headers and value words according to the picked slot's permission header. It reports the outcome in a two-bit status register. The value store is an on-chip dual-port RAM that starts in the erased state of all ones. Header storage is a register array that a synchronous reset returns to all ones.

A request is a one-cycle strobe carrying write, secure, word address and write data. The response pulse comes two clock edges later. Refused reads return the poison word 0xDEADDEAD. Clearing the STATE bit of a slot's permission header revokes the slot. Revocation overwrites all four of its value words with zero in the same cycle, and every later value read of that slot returns poison.

Top module: `kslot_access_ctrl`

## Requirements
- R1: A request presented on an edge with req_valid high produces rsp_ready high for exactly the cycle after the second following edge, with rsp_ready low in between. A new request may be presented in the cycle in which rsp_ready is high. Write responses carry rdata 0.
- R2: After reset the select register and status read 0, every permission header reads 0x0000000F, and every destination header reads 0xFFFFFFFF. Value words start at 0xFFFFFFFF.
- R3: The word address is {region[1:0], slot index, word[1:0]}, where region 0 is control, 1 is the permission header, 2 is the destination header and 3 is a value word. Slot ID N (1..NUM_SLOTS) addresses slot index N-1. In the control region, word bit 0 = 0 is the select register and bit 0 = 1 is the status register.
- R4: A secure write of a value 0..NUM_SLOTS to the select register stores it, where 0 means no slot is selected. A larger value stores 0 and sets BLOCKED.
- R5: Status bit 0 is SELECTED and bit 1 is BLOCKED. Both are cleared by every secure select write. SELECTED is set by a successful access to the selected slot, and BLOCKED is set by any refused access. Control reads leave status unchanged.
- R6: Secure header reads of any slot are always served. Such a read sets SELECTED only when it addresses the selected slot.
- R7: A header write is applied only when a slot is selected and the write addresses it; otherwise it is refused. An applied write ANDs the data into the old value, so bits can only clear. Permission bits are bit 3 STATE, bit 2 PUSH, bit 1 READ and bit 0 WRITE.
- R8: A value read returns the word only when it addresses the selected slot and that slot has STATE=1 and READ=1. Otherwise it returns 0xDEADDEAD and sets BLOCKED.
- R9: A value write is applied only when it addresses the selected slot, that slot's permission header is still 0xF, and the target word still holds 0xFFFFFFFF. Otherwise it is refused and the word is unchanged.
- R10: A header write that leaves STATE=0 revokes the slot. Its value words become 0, and every later value read of it returns 0xDEADDEAD whatever its READ bit.
- R11: Every non-secure request is refused. Reads return 0xDEADDEAD, writes change no state, and BLOCKED is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Transaction is secure |
| req_addr | input | ADDR_W | Word address {region, slot index, word} |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Response strobe, two edges after the request |
| rsp_rdata | output | 32 | Read data, poison on refusal, 0 for writes |

## Verification
The assertions take for granted that the master keeps at most one request in flight. A request must not be presented in the cycle after another, because the value RAM is read on the request edge and written one edge later. The bench drives every request as a one-cycle strobe and waits for its response before the next, so that assumption always holds. The bench sweeps select values beyond the slot count, every slot of a small configuration, and eight permission patterns that cover readable, unreadable, revoked and still-empty headers. Each response and each status value is predicted by an arithmetic model of the rules.

// File: rtl/kslot_pkg.sv
package kslot_pkg;
  localparam logic [31:0] POISON_WORD = 32'hDEADDEAD;
  localparam int PERM_W  = 4;
  localparam int P_STATE = 3;
  localparam int P_PUSH  = 2;
  localparam int P_READ  = 1;
  localparam int P_WRITE = 0;

  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_PERM = 2'd1,
    RG_DEST = 2'd2,
    RG_VAL  = 2'd3
  } region_e;
endpackage

// File: rtl/kslot_value_ram.sv
module kslot_value_ram #(
  parameter int DEPTH  = 128,
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int ROW_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [ROW_W-1:0] rd_row,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] wr_lane,
  input  logic [ROW_W-1:0] wr_data
);
  logic [ROW_W-1:0] mem [DEPTH];

  // erased storage at power-up
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lane[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_row <= mem[rd_addr];
  end
endmodule

// File: rtl/kslot_policy.sv
module kslot_policy
  import kslot_pkg::*;
(
  input  logic              secure,
  input  logic              write,
  input  region_e           region,
  input  logic              slot_match,
  input  logic [PERM_W-1:0] perm,
  input  logic              word_erased,
  output logic              grant,
  output logic              hit,
  output logic              blocked
);
  always_comb begin
    grant = 1'b0;
    hit   = 1'b0;
    if (secure) begin
      case (region)
        RG_CTRL: grant = 1'b1;
        RG_PERM, RG_DEST: begin
          grant = !write || slot_match;
          hit   = slot_match;
        end
        RG_VAL: begin
          if (write) grant = slot_match && (&perm) && word_erased;
          else       grant = slot_match && perm[P_STATE] && perm[P_READ];
          hit = grant;
        end
        default: grant = 1'b0;
      endcase
    end
    blocked = !grant;
  end
endmodule

// File: rtl/kslot_access_ctrl.sv
module kslot_access_ctrl
  import kslot_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int WSEL_W   = $clog2(WORDS),
  localparam int ADDR_W   = 2 + IDX_W + WSEL_W,
  localparam int SEL_W    = $clog2(NUM_SLOTS + 1),
  localparam int ROW_W    = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  // stage 1: captured request
  logic              s1_valid, s1_write, s1_secure;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_write <= 1'b0;
      s1_secure <= 1'b0;
      s1_addr <= '0;
      s1_wdata <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_write  <= req_write;
        s1_secure <= req_secure;
        s1_addr   <= req_addr;
        s1_wdata  <= req_wdata;
      end
    end
  end

  region_e            s1_region;
  logic [IDX_W-1:0]   s1_idx;
  logic [WSEL_W-1:0]  s1_word;
  assign s1_region = region_e'(s1_addr[ADDR_W-1 -: 2]);
  assign s1_idx    = s1_addr[WSEL_W +: IDX_W];
  assign s1_word   = s1_addr[WSEL_W-1:0];

  // selection and status
  logic [SEL_W-1:0]  sel_q;
  logic              st_sel_q, st_blk_q;
  logic [PERM_W-1:0] perm_q [NUM_SLOTS];
  logic [DATA_W-1:0] dest_q [NUM_SLOTS];

  logic slot_match, id_ok, sel_wr, ctrl_wr;
  assign slot_match = (sel_q != '0) && (SEL_W'(s1_idx) + SEL_W'(1) == sel_q);
  assign id_ok      = s1_wdata <= DATA_W'(NUM_SLOTS);
  assign ctrl_wr    = s1_secure && s1_write && (s1_region == RG_CTRL);
  assign sel_wr     = ctrl_wr && !s1_addr[0];

  // value RAM
  logic [ROW_W-1:0]  ram_row, ram_wdata;
  logic [WORDS-1:0]  ram_lane;
  logic              ram_we;
  logic [DATA_W-1:0] cur_word;
  assign cur_word = ram_row[s1_word*DATA_W +: DATA_W];

  kslot_value_ram #(.DEPTH(NUM_SLOTS), .LANES(WORDS), .LANE_W(DATA_W)) u_ram (
    .clk    (clk),
    .rd_en  (req_valid),
    .rd_addr(req_addr[WSEL_W +: IDX_W]),
    .rd_row (ram_row),
    .wr_en  (ram_we),
    .wr_addr(s1_idx),
    .wr_lane(ram_lane),
    .wr_data(ram_wdata)
  );

  logic pol_grant, pol_hit, pol_blocked;
  kslot_policy u_pol (
    .secure     (s1_secure),
    .write      (s1_write),
    .region     (s1_region),
    .slot_match (slot_match),
    .perm       (perm_q[s1_idx]),
    .word_erased(&cur_word),
    .grant      (pol_grant),
    .hit        (pol_hit),
    .blocked    (pol_blocked)
  );

  logic [PERM_W-1:0] perm_new;
  logic              do_val_wr, do_perm_wr, do_dest_wr, do_revoke;
  assign perm_new   = perm_q[s1_idx] & s1_wdata[PERM_W-1:0];
  assign do_val_wr  = s1_valid && s1_write && pol_grant && (s1_region == RG_VAL);
  assign do_perm_wr = s1_valid && s1_write && pol_grant && (s1_region == RG_PERM);
  assign do_dest_wr = s1_valid && s1_write && pol_grant && (s1_region == RG_DEST);
  assign do_revoke  = do_perm_wr && !perm_new[P_STATE];

  always_comb begin
    ram_we    = do_val_wr || do_revoke;
    ram_lane  = do_revoke ? '1 : (WORDS'(1) << s1_word);
    ram_wdata = do_revoke ? '0 : {WORDS{s1_wdata}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        perm_q[i] <= '1;
        dest_q[i] <= '1;
      end
    end else begin
      if (do_perm_wr) perm_q[s1_idx] <= perm_new;
      if (do_dest_wr) dest_q[s1_idx] <= dest_q[s1_idx] & s1_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      st_sel_q <= 1'b0;
      st_blk_q <= 1'b0;
    end else if (s1_valid) begin
      if (sel_wr) begin
        sel_q    <= id_ok ? s1_wdata[SEL_W-1:0] : '0;
        st_sel_q <= 1'b0;
        st_blk_q <= !id_ok;
      end else if (!ctrl_wr) begin
        if (pol_hit)     st_sel_q <= 1'b1;
        if (pol_blocked) st_blk_q <= 1'b1;
      end
    end
  end

  // response
  logic [DATA_W-1:0] rd_word;
  always_comb begin
    case (s1_region)
      RG_CTRL: rd_word = s1_addr[0] ? DATA_W'({st_blk_q, st_sel_q}) : DATA_W'(sel_q);
      RG_PERM: rd_word = DATA_W'(perm_q[s1_idx]);
      RG_DEST: rd_word = dest_q[s1_idx];
      default: rd_word = cur_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= s1_valid;
      if (s1_valid) rsp_rdata <= s1_write ? '0 : (pol_grant ? rd_word : POISON_WORD);
    end
  end

  // assertions
  a_r1_rsp_two_edges: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##2 rsp_ready);
  a_r1_one_in_flight: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> !req_valid);
  a_r4_select_range: assert property (@(posedge clk) disable iff (rst)
    sel_q <= SEL_W'(NUM_SLOTS));
  a_r5_select_clears: assert property (@(posedge clk) disable iff (rst)
    s1_valid && sel_wr && id_ok |=> !st_sel_q && !st_blk_q);
  a_r7_perm_only_clears: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> (perm_q[$past(s1_idx)] & ~$past(perm_q[s1_idx])) == '0);
  a_r10_revoked_poison: assert property (@(posedge clk) disable iff (rst)
    s1_valid && s1_secure && !s1_write && s1_region == RG_VAL && !perm_q[s1_idx][P_STATE]
    |=> rsp_rdata == POISON_WORD && st_blk_q);
  a_r11_nonsecure: assert property (@(posedge clk) disable iff (rst)
    s1_valid && !s1_secure |=> st_blk_q && rsp_rdata == ($past(s1_write) ? '0 : POISON_WORD));
endmodule

// File: tb/sim_kslot_access_ctrl.sv
`timescale 1ns/1ps
module sim_kslot_access_ctrl;
  localparam int NS = 8;
  localparam int AW = 7;
  localparam logic [31:0] POISON = 32'hDEADDEAD;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready;
  logic [31:0] rsp_rdata;

  always #10 clk = ~clk;

  kslot_access_ctrl #(.NUM_SLOTS(NS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model
  int m_sel = 0;
  bit m_ss = 0, m_sb = 0;
  logic [3:0]  m_perm [NS];
  logic [31:0] m_dest [NS];
  logic [31:0] m_val  [NS][4];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic raw(input bit wr, input bit sec, input int rg, input int si, input int wd,
                     input logic [31:0] d, output logic [31:0] got);
    req_valid = 1; req_write = wr; req_secure = sec; req_wdata = d;
    req_addr = {rg[1:0], si[2:0], wd[1:0]};
    @(negedge clk);
    req_valid = 0;
    chk("R1 ready low between", {31'b0, rsp_ready}, 32'd0);
    @(negedge clk);
    chk("R1 ready pulse", {31'b0, rsp_ready}, 32'd1);
    got = rsp_rdata;
  endtask

  task automatic xact(input bit wr, input bit sec, input int rg, input int si, input int wd,
                      input logic [31:0] d, input string tag);
    logic [31:0] exp, got;
    bit m;
    exp = 0;
    m = (m_sel != 0) && (si + 1 == m_sel);
    if (!sec) begin
      m_sb = 1; exp = wr ? 0 : POISON;
    end else case (rg)
      0: if (wr) begin
           if (wd[0] == 0) begin
             m_ss = 0;
             if (d <= NS) begin m_sel = d; m_sb = 0; end
             else begin m_sel = 0; m_sb = 1; end
           end
         end else exp = wd[0] ? {30'b0, m_sb, m_ss} : m_sel;
      1: if (wr) begin
           if (m) begin
             m_perm[si] = m_perm[si] & d[3:0]; m_ss = 1;
             if (!m_perm[si][3]) for (int k = 0; k < 4; k++) m_val[si][k] = 0;
           end else m_sb = 1;
         end else begin exp = {28'b0, m_perm[si]}; if (m) m_ss = 1; end
      2: if (wr) begin
           if (m) begin m_dest[si] = m_dest[si] & d; m_ss = 1; end else m_sb = 1;
         end else begin exp = m_dest[si]; if (m) m_ss = 1; end
      default: if (wr) begin
           if (m && m_perm[si] == 4'hF && m_val[si][wd] == 32'hFFFFFFFF) begin
             m_val[si][wd] = d; m_ss = 1;
           end else m_sb = 1;
         end else begin
           if (m && m_perm[si][3] && m_perm[si][1]) begin exp = m_val[si][wd]; m_ss = 1; end
           else begin exp = POISON; m_sb = 1; end
         end
    endcase
    raw(wr, sec, rg, si, wd, d, got);
    chk(tag, got, exp);
    raw(0, 1, 0, 0, 1, 0, got);
    chk("R5 status", got, {30'b0, m_sb, m_ss});
  endtask

  logic [3:0] ptab [8] = '{4'hF, 4'hE, 4'hC, 4'hA, 4'h6, 4'h3, 4'hB, 4'h7};

  initial begin
    for (int i = 0; i < NS; i++) begin
      m_perm[i] = 4'hF; m_dest[i] = '1;
      for (int k = 0; k < 4; k++) m_val[i][k] = '1;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 ready after reset", {31'b0, rsp_ready}, 32'd0);
    xact(0, 1, 0, 0, 0, 0, "R2 select reset");
    for (int s = 0; s < NS; s++) begin
      xact(0, 1, 1, s, 0, 0, "R2 R6 perm header");
      xact(0, 1, 2, s, 0, 0, "R2 R6 dest header");
    end
    xact(0, 1, 3, 0, 0, 0, "R8 read unselected");
    xact(1, 1, 3, 0, 0, 32'h1, "R9 write unselected");
    xact(1, 1, 1, 0, 0, 32'h0, "R7 perm write unselected");
    for (int id = 0; id < 13; id++) begin
      xact(1, 1, 0, 0, 0, id, "R4 select write");
      xact(0, 1, 0, 0, 0, 0, "R4 select readback");
    end
    xact(1, 0, 0, 0, 0, 3, "R11 nonsecure select");
    xact(0, 1, 0, 0, 0, 0, "R11 select unchanged");
    for (int s = 0; s < NS; s++) begin
      int o = (s + 3) % NS;
      xact(1, 1, 0, 0, 0, s + 1, "R3 R4 select slot");
      xact(0, 1, 1, o, 0, 0, "R6 header read other slot");
      xact(1, 1, 2, s, 0, 32'hFF00FF00 ^ (s << 4), "R7 dest write");
      xact(1, 1, 2, o, 0, 32'h0, "R7 dest write other slot");
      xact(0, 1, 2, o, 0, 0, "R7 other dest unchanged");
      for (int w = 0; w < 4; w++) xact(1, 1, 3, s, w, 32'h1000_0000 * s + 32'h111 * w, "R9 value write");
      for (int w = 0; w < 4; w++) xact(0, 1, 3, s, w, 0, "R8 value read");
      xact(1, 1, 3, s, 0, 32'h0, "R9 rewrite refused");
      xact(0, 1, 3, s, 0, 0, "R9 word unchanged");
      xact(0, 1, 3, o, 1, 0, "R8 other slot read");
      xact(1, 0, 3, s, 1, 32'h0, "R11 nonsecure value write");
      xact(0, 0, 3, s, 1, 0, "R11 nonsecure value read");
      xact(0, 1, 3, s, 1, 0, "R11 value unchanged");
      xact(1, 1, 1, s, 0, {28'b0, ptab[s]}, "R7 R10 perm write");
      xact(1, 1, 1, s, 0, 32'hF, "R7 perm only clears");
      xact(0, 1, 1, s, 0, 0, "R7 perm readback");
      for (int w = 0; w < 4; w++) xact(0, 1, 3, s, w, 0, "R8 R10 read after perm");
      xact(1, 1, 3, s, 2, 32'h0, "R9 write after perm");
      xact(0, 1, 3, s, 2, 0, "R9 R10 read after write");
    end
    xact(1, 1, 0, 0, 0, 0, "R4 deselect");
    xact(0, 1, 3, 4, 0, 0, "R10 revoked unselected");
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule